// File: doc/BRIEF.md
# Protected Oscillator Enable Controller

This block controls a high-speed reference oscillator and the multiplier mode of the clock multiplier after it. Software reaches it through a small register bus. It can start or stop the oscillator by writing an enable bit, but only after it has loaded an unlock key into a separate key register. A request to stop the oscillator is refused while that oscillator feeds the CPU clock.

A sleep input overrides the enable bit and holds the oscillator off. When sleep ends, the oscillator restarts only if the enable bit is still set. Each time the oscillator goes from off to on, a settling counter starts from zero. A clock-ready flag rises only after the counter has run for the configured number of reference-clock cycles. Two strap pins are decoded into a multiplier mode, and one reserved strap code is flagged as invalid.

Top module: `osc_gate_ctl`

## Requirements
- R1: After reset the enable bit is 1, the key register holds 0x00, and `clk_ready` is 0.
- R2: A write to the power register changes nothing unless the key register holds 0x96.
- R3: With the key register at 0x96, a power-register write takes `bus_wdata[1]` as the new enable bit. A 1 starts the oscillator and a 0 stops it.
- R4: A power-register write of 0 to the enable bit is ignored while `cpu_on_hsosc` is 1.
- R5: `osc_run` is 0 whenever `sleep_req` is 1. After sleep it returns to 1 only if the enable bit is 1, and the enable bit is not changed by sleep.
- R6: `clk_ready` is 1 only once `osc_run` has been 1 for SETTLE_CYC consecutive clock edges. It drops when the oscillator stops, and it waits for a fresh count after every off-to-on transition.
- R7: `mult_mode` decodes `strap` as follows: 2'b11 gives 1 (x2), 2'b01 gives 2 (x4), 2'b00 gives 0 (bypass), and the reserved code 2'b10 gives 0 with `strap_bad` set to 1. For every other code `strap_bad` is 0.
- R8: Reads are combinational. The power register (offset PWR_OFS, default 0) returns the enable bit at bit 1 with every other bit 0. The key register (offset KEY_OFS, default 1) returns its content, and any other offset returns 0. A write to KEY_OFS stores `bus_wdata` unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sleep_req | input | 1 | CPU sleep state |
| cpu_on_hsosc | input | 1 | The high-speed oscillator is the CPU clock source |
| strap | input | 2 | Multiplier strap pins |
| osc_run | output | 1 | Oscillator enable to the analog cell |
| clk_ready | output | 1 | Oscillator settled |
| mult_mode | output | 2 | 0 bypass, 1 x2, 2 x4 |
| strap_bad | output | 1 | Reserved strap code seen |

## Verification
The enable bit is driven by power-register writes made with the key locked, then unlocked, then unlocked while the oscillator is the CPU clock. Comparing these cases separates the key gate from the CPU-clock guard. Sleep pulses are applied with the enable bit set and with it cleared. These show that wake-up depends on the enable bit and that every restart brings a fresh settling count rather than a resumed one. All four strap codes are swept, and the key register is read back at several values.

// File: rtl/osc_gate_ctl.sv
module osc_gate_ctl #(
  parameter int AW = 4,
  parameter logic [AW-1:0] PWR_OFS = 0,
  parameter logic [AW-1:0] KEY_OFS = 1,
  parameter logic [7:0] UNLOCK_KEY = 8'h96,
  parameter int SETTLE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  output logic [7:0]    bus_rdata,
  input  logic          sleep_req,
  input  logic          cpu_on_hsosc,
  input  logic [1:0]    strap,
  output logic          osc_run,
  output logic          clk_ready,
  output logic [1:0]    mult_mode,
  output logic          strap_bad
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(SETTLE_CYC);

  logic          en_q;
  logic [7:0]    key_q;
  logic [CW-1:0] cnt_q;

  wire pwr_wr   = bus_we && (bus_addr == PWR_OFS);
  wire key_wr   = bus_we && (bus_addr == KEY_OFS);
  wire unlocked = (key_q == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      key_q <= 8'h00;
    end else begin
      if (key_wr) key_q <= bus_wdata;
      if (pwr_wr && unlocked && (bus_wdata[1] || !cpu_on_hsosc))
        en_q <= bus_wdata[1];
    end
  end

  assign osc_run = en_q && !sleep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!osc_run)          cnt_q <= '0;
    else if (cnt_q != CNT_DONE) cnt_q <= cnt_q + 1'b1;
  end

  assign clk_ready = osc_run && (cnt_q == CNT_DONE);

  always_comb begin
    unique case (strap)
      2'b11:   mult_mode = 2'd1;
      2'b01:   mult_mode = 2'd2;
      default: mult_mode = 2'd0;
    endcase
  end
  assign strap_bad = (strap == 2'b10);

  always_comb begin
    if (bus_addr == PWR_OFS)      bus_rdata = {6'b0, en_q, 1'b0};
    else if (bus_addr == KEY_OFS) bus_rdata = key_q;
    else                          bus_rdata = 8'h00;
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && !unlocked) |=> (en_q == $past(en_q))); // R2
  AST_NO_STOP_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_on_hsosc && en_q) |=> en_q); // R4
  AST_SLEEP_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !pwr_wr) |=> (en_q == $past(en_q))); // R5
  AST_FRESH_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_run) |-> !clk_ready); // R6
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && osc_run) |=> (clk_ready || !osc_run)); // R6
  AST_BAD_STRAP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    strap_bad |-> (mult_mode == 2'd0)); // R7
endmodule

// File: tb/osc_gate_ctl_tb.sv
module osc_gate_ctl_tb_top;
  localparam int S = 12;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic bus_we = 0, sleep_req = 0, cpu_on_hsosc = 0;
  logic [1:0] strap = 2'b00;
  logic [7:0] bus_rdata;
  logic osc_run, clk_ready, strap_bad;
  logic [1:0] mult_mode;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  osc_gate_ctl #(.AW(4), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .cpu_on_hsosc(cpu_on_hsosc), .strap(strap), .osc_run(osc_run),
    .clk_ready(clk_ready), .mult_mode(mult_mode), .strap_bad(strap_bad));

  bit m_en = 1;
  int m_key = 0;
  int m_run_cycles = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 1; m_key = 0; m_run_cycles = 0;
    end else begin
      if (m_en && !sleep_req) m_run_cycles = m_run_cycles + 1;
      else m_run_cycles = 0;
      if (bus_we && bus_addr == 1) m_key = bus_wdata;
      if (bus_we && bus_addr == 0 && m_key == 8'h96) begin
        if (bus_wdata[1]) m_en = 1;
        else if (!cpu_on_hsosc) m_en = 0;
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit run;
      int rd;
      run = m_en && !sleep_req;
      rd = (bus_addr == 0) ? (m_en ? 2 : 0) : (bus_addr == 1) ? m_key : 0;
      check("R3/R5 osc_run", osc_run, run);
      check("R6 clk_ready", clk_ready, run && m_run_cycles >= S);
      check("R8 bus_rdata", bus_rdata, rd);
      check("R7 mult_mode", mult_mode,
            strap == 2'b11 ? 1 : strap == 2'b01 ? 2 : 0);
      check("R7 strap_bad", strap_bad, strap == 2'b10);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int d);
    bus_addr = a[3:0]; bus_wdata = d[7:0]; bus_we = 1;
    step();
    bus_we = 0; bus_addr = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    #1;
    check("R1 reset enable", bus_rdata, 2);
    check("R1 reset ready", clk_ready, 0);
    bus_addr = 1; #1;
    check("R1 reset key", bus_rdata, 0);
    bus_addr = 0;
    step(S + 3);
    wr(0, 0);
    step(2);
    check("R2 locked write ignored", osc_run, 1);
    wr(1, 8'h95);
    wr(0, 0);
    check("R2 wrong key ignored", osc_run, 1);
    wr(1, 8'h96);
    wr(0, 0);
    check("R3 stop", osc_run, 0);
    step(4);
    wr(0, 2);
    check("R3 start", osc_run, 1);
    step(S + 2);
    cpu_on_hsosc = 1;
    wr(0, 0);
    check("R4 stop refused", osc_run, 1);
    step(2);
    cpu_on_hsosc = 0;
    sleep_req = 1; step(5);
    check("R5 sleep forces off", osc_run, 0);
    sleep_req = 0; step(3);
    check("R5 wake resumes", osc_run, 1);
    step(S);
    wr(0, 0);
    sleep_req = 1; step(3);
    sleep_req = 0; step(3);
    check("R5 wake stays off when disabled", osc_run, 0);
    wr(0, 2);
    step(S / 2);
    sleep_req = 1; step(1); sleep_req = 0;
    step(S + 2);
    wr(1, 8'h3C);
    bus_addr = 1; step(1);
    bus_addr = 5; step(1);
    bus_addr = 0;
    for (int i = 0; i < 4; i++) begin
      strap = i[1:0];
      step(2);
    end
    step(3);
    summary();
  end
endmodule